// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division over many clock cycles and parks its results in a dedicated pair of result registers, called HI and LO, rather than in a general register. A caller raises `start` for one cycle with an operation code and two operands. The unit then runs for a fixed number of cycles with `busy` raised. When it finishes, it writes both result registers in the same clock.

A multiply produces a double-width product: the upper half lands in HI and the lower half in LO. A divide places the quotient in LO and the remainder in HI. Signed variants work on operand magnitudes and correct the result signs at the end. No variant ever flags overflow, and division by zero completes normally with defined results.

The two result registers are always visible on the `hi` and `lo` ports. A move-from-HI or move-from-LO operation elsewhere in the pipeline reads them there. That logic only needs to wait while `busy` is high.

Top module: `hilo_muldiv`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0 and both `hi` and `lo` are 0.
- R2: An operation is accepted when `start` is 1 at a clock edge while `busy` is 0. The `op` encoding is 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide and 2'b11 unsigned divide.
- R3: `busy` rises at the clock edge that accepts an operation and stays high for 33 cycles. `hi` and `lo` take their new values at the edge where `busy` falls.
- R4: A multiply writes the upper 32 bits of the 64-bit product to `hi` and the lower 32 bits to `lo`. The unsigned form treats operands as unsigned; the signed form treats them as two's complement.
- R5: An unsigned divide writes the quotient to `lo` and the remainder to `hi`.
- R6: A signed divide truncates the quotient toward zero and gives the remainder the sign of the dividend.
- R7: A divide with a zero divisor, signed or unsigned, writes all ones to `lo` and the dividend unchanged to `hi`.
- R8: A `start` while `busy` is 1 is ignored. The running operation finishes with its own result, and no second operation follows.
- R9: `hi` and `lo` keep their values between completions.
- R10: No variant signals overflow. A signed multiply of two most-negative operands and a signed divide of the most-negative value by -1 give the wrapped results (`hi`=0x40000000, `lo`=0, and `lo`=0x80000000, `hi`=0 respectively).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code, sampled with `start` |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| hi | output | 32 | HI result register: product upper half or remainder |
| lo | output | 32 | LO result register: product lower half or quotient |

## Verification
Each operation code is driven with operand pairs chosen to separate the sign paths: all-ones unsigned operands, small mixed-sign values, and most-negative values. These show whether the sign correction is applied only to the signed variants and only when the operand signs differ. Divides are run with every sign combination of dividend and divisor, which separates truncation toward zero from floor division and checks that the remainder follows the dividend. Zero divisors, the most-negative / -1 case, a start pulse in the middle of an operation, and long idle gaps check the defined corner results, the rejection of a second request, and the holding of HI and LO.

// File: rtl/hilo_pkg.sv
// Package: shared operation codes and helpers for the HI/LO multiply/divide unit.
// Assumes op[1] selects divide and op[0] selects the unsigned form.
package hilo_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } hilo_op_e;

    // True when the operation treats its operands as two's complement.
    function automatic logic op_is_signed(input logic [1:0] code);
        return (code == OP_MUL_S) || (code == OP_DIV_S);
    endfunction

    // True when the operation is a divide.
    function automatic logic op_is_div(input logic [1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/hilo_mul_core.sv
// Module: shift-add multiplier core, one multiplier bit per step.
// Assumes unsigned magnitudes on load; after W steps prod holds the full product.
module hilo_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [W:0]     sum;

    // Add the multiplicand into the upper half when the current multiplier bit is set.
    always_comb begin
        sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    end

    // Load the operands, or shift the partial product right by one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand;
            prod_q  <= {{W{1'b0}}, mplier};
        end else if (step) begin
            prod_q  <= {sum, prod_q[W-1:1]};
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/hilo_div_core.sv
// Module: restoring divider core, one quotient bit per step.
// Assumes unsigned magnitudes on load; a zero divisor yields all-ones quotient
// and remainder equal to the dividend without special handling.
module hilo_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] dvs_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] rem_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;

    // Shift the next dividend bit into the remainder and trial-subtract the divisor.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
    end

    // Load the operands, or keep or restore the remainder and record the quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            dvs_q <= dvs;
            quo_q <= dvd;
            rem_q <= '0;
        end else if (step) begin
            rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    // R5: the partial remainder stays below a nonzero divisor at every step.
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q));

    assign quo = quo_q;
    assign rem = rem_q;
endmodule

// File: rtl/hilo_muldiv.sv
// Module: multiply/divide unit with a HI/LO result pair.
// Accepts one operation when idle, runs W steps plus one write cycle, then
// writes HI and LO together. Signed forms work on magnitudes, with a sign fix at the end.
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic           busy_q;
    logic [CW-1:0]  cnt_q;
    logic           div_q;
    logic           neg_main_q;
    logic           neg_rem_q;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;

    logic           accept;
    logic           done;
    logic           stepping;
    logic           a_neg;
    logic           b_neg;
    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    logic [2*W-1:0] prod;
    logic [2*W-1:0] prod_fix;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic [W-1:0]   quo_fix;
    logic [W-1:0]   rem_fix;

    // Decode the request: acceptance, operand signs and magnitudes.
    always_comb begin
        accept   = start && !busy_q;
        done     = busy_q && (cnt_q == LAST);
        stepping = busy_q && !done;
        a_neg    = op_is_signed(op) && opa[W-1];
        b_neg    = op_is_signed(op) && opb[W-1];
        mag_a    = a_neg ? (~opa + 1'b1) : opa;
        mag_b    = b_neg ? (~opb + 1'b1) : opb;
    end

    hilo_mul_core #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && !op_is_div(op)),
        .step   (stepping && !div_q),
        .mcand  (mag_a),
        .mplier (mag_b),
        .prod   (prod)
    );

    hilo_div_core #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && op_is_div(op)),
        .step  (stepping && div_q),
        .dvd   (mag_a),
        .dvs   (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    // Restore the result signs from the magnitudes.
    always_comb begin
        prod_fix = neg_main_q ? (~prod + 1'b1) : prod;
        quo_fix  = neg_main_q ? (~quo + 1'b1) : quo;
        rem_fix  = neg_rem_q ? (~rem + 1'b1) : rem;
    end

    // Sequence the operation: latch the kind and signs, count the steps, drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            div_q      <= 1'b0;
            neg_main_q <= 1'b0;
            neg_rem_q  <= 1'b0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            cnt_q      <= '0;
            div_q      <= op_is_div(op);
            neg_main_q <= (a_neg ^ b_neg) && !(op_is_div(op) && (opb == '0));
            neg_rem_q  <= a_neg;
        end else if (done) begin
            busy_q     <= 1'b0;
        end else if (stepping) begin
            cnt_q      <= cnt_q + 1'b1;
        end
    end

    // Write HI and LO together on the final cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (done) begin
            hi_q <= div_q ? rem_fix : prod_fix[2*W-1:W];
            lo_q <= div_q ? quo_fix : prod_fix[W-1:0];
        end
    end

    assign busy = busy_q;
    assign hi   = hi_q;
    assign lo   = lo_q;

    // R2: busy only rises in response to a start request.
    a_r2_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start));

    // R3: busy falls only after the full step count.
    a_r3_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == LAST));

    // R8: a start during a step does not restart the count.
    a_r8_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && (cnt_q != LAST)) |=> (busy_q && (cnt_q == $past(cnt_q) + 1'b1)));

    // R9: HI and LO change only at completion.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hi_q) || !$stable(lo_q)) |-> $fell(busy_q));
endmodule

// File: tb/sim_hilo_muldiv.sv
`timescale 1ns/1ps
module sim_hilo_muldiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy;
    logic [31:0] hi;
    logic [31:0] lo;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // Reference model state
    bit          m_busy = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] p_hi = '0;
    logic [31:0] p_lo = '0;

    always #5 clk = ~clk;

    hilo_muldiv u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .hi(hi), .lo(lo)
    );

    // Behavioural result from the requirements (R4..R7, R10).
    task automatic compute(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] rh, output logic [31:0] rl);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'({32'b0, a});
        longint ub = longint'({32'b0, b});
        longint r;
        case (c)
            2'b00: begin r = sa * sb; rh = r[63:32]; rl = r[31:0]; end
            2'b01: begin r = ua * ub; rh = r[63:32]; rl = r[31:0]; end
            2'b10: begin
                if (b == 0) begin rl = '1; rh = a; end
                else begin r = sa / sb; rl = r[31:0]; r = sa % sb; rh = r[31:0]; end
            end
            default: begin
                if (b == 0) begin rl = '1; rh = a; end
                else begin r = ua / ub; rl = r[31:0]; r = ua % ub; rh = r[31:0]; end
            end
        endcase
    endtask

    // Cycle model: accepts when idle, completes 33 edges later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_hi = '0; m_lo = '0;
        end else if (!m_busy && start) begin
            compute(op, opa, opb, p_hi, p_lo);
            m_busy = 1; m_cnt = 33;
        end else if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_busy = 0; m_hi = p_hi; m_lo = p_lo;
            end
        end
    end

    task automatic check32(input string tag, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check32((m_busy != busy) ? "R3" : cur_tag, "busy", {31'b0, busy}, {31'b0, m_busy});
            check32(cur_tag, "hi", hi, m_hi);
            check32(cur_tag, "lo", lo, m_lo);
        end
    end

    task automatic run_op(input string tag, input logic [1:0] c, input logic [31:0] a,
                          input logic [31:0] b);
        cur_tag = tag;
        @(negedge clk);
        start = 1'b1; op = c; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check32("R3", "busy after accept", {31'b0, busy}, 32'd1);
        repeat (33) @(negedge clk);
        check32("R3", "busy after completion", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check32("R1", "reset busy", {31'b0, busy}, 32'd0);
        check32("R1", "reset hi", hi, 32'd0);
        check32("R1", "reset lo", lo, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op("R4", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check32("R4", "unsigned max hi", hi, 32'hFFFF_FFFE);
        check32("R4", "unsigned max lo", lo, 32'h0000_0001);
        run_op("R4", 2'b00, 32'hFFFF_FFFD, 32'd7);
        check32("R4", "signed -3*7 hi", hi, 32'hFFFF_FFFF);
        check32("R4", "signed -3*7 lo", lo, 32'hFFFF_FFEB);
        run_op("R4", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R4", 2'b01, 32'd12345, 32'd6789);
        run_op("R10", 2'b00, 32'h8000_0000, 32'h8000_0000);
        check32("R10", "minneg square hi", hi, 32'h4000_0000);
        check32("R10", "minneg square lo", lo, 32'h0);

        run_op("R5", 2'b11, 32'd100, 32'd7);
        check32("R5", "100/7 quotient", lo, 32'd14);
        check32("R5", "100/7 remainder", hi, 32'd2);
        run_op("R5", 2'b11, 32'hFFFF_FFFF, 32'd16);
        run_op("R6", 2'b10, 32'hFFFF_FFF9, 32'd2);
        check32("R6", "-7/2 quotient", lo, 32'hFFFF_FFFD);
        check32("R6", "-7/2 remainder", hi, 32'hFFFF_FFFF);
        run_op("R6", 2'b10, 32'd7, 32'hFFFF_FFFE);
        check32("R6", "7/-2 remainder", hi, 32'd1);
        run_op("R6", 2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
        check32("R6", "-7/-2 quotient", lo, 32'd3);

        run_op("R7", 2'b11, 32'h1234_5678, 32'd0);
        check32("R7", "udiv0 quotient", lo, 32'hFFFF_FFFF);
        check32("R7", "udiv0 remainder", hi, 32'h1234_5678);
        run_op("R7", 2'b10, 32'hFFFF_FFFB, 32'd0);
        check32("R7", "sdiv0 quotient", lo, 32'hFFFF_FFFF);
        check32("R7", "sdiv0 remainder", hi, 32'hFFFF_FFFB);
        run_op("R10", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
        check32("R10", "minneg/-1 quotient", lo, 32'h8000_0000);
        check32("R10", "minneg/-1 remainder", hi, 32'h0);

        // R8: a second start mid-operation must be dropped.
        cur_tag = "R8";
        @(negedge clk);
        start = 1'b1; op = 2'b11; opa = 32'd50; opb = 32'd5;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; op = 2'b01; opa = 32'd3; opb = 32'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        check32("R8", "first quotient kept", lo, 32'd10);
        check32("R8", "first remainder kept", hi, 32'd0);
        check32("R8", "no second op", {31'b0, busy}, 32'd0);

        // R9: idle gap with changing inputs but no start.
        cur_tag = "R9";
        opa = 32'hDEAD_BEEF; opb = 32'h1;
        repeat (20) @(negedge clk);
        check32("R9", "hi held", hi, 32'd0);
        check32("R9", "lo held", lo, 32'd10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule